// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the synchronous device-side front end of a 16-bit parallel flash. It watches single-cycle bus writes and decodes the unlock-prefixed command sequences that software uses to change the flash. It turns them into one-cycle requests on an abstract array port: program a word, erase a set of sectors, or record the boot-region lock. The storage array is outside the block. The block reads the array through a combinational port addressed by the bus address, and it writes the array only through the request port.

Reads are answered one cycle after the read strobe. Outside an operation the answer is array data, or identification words when identification mode is active. While a program or erase runs, which lasts a fixed number of cycles set by parameters, the answer is a status word. In that word bit 7 is a completion flag and bit 6 toggles on every read. A lock flag protects the lowest 8K words. A plain override input lifts that protection.

Top module: `flash_cmd_if`

## Requirements
- R1: Writes of AA at 5555 and 55 at 2AAA, then A0 at 5555, then any address and word, raise `op_valid` with `op_kind`=1 in the cycle after the last write. That request carries `op_addr` equal to the written address and `op_data` equal to the array word at that address ANDed with the written word.
- R2: Command matching uses only address bits 14:0 and data bits 7:0. Higher address bits and data bits 15:8 do not affect decoding.
- R3: A write that does not fit the next expected step abandons the sequence. If that write is AA at 5555, it counts as the first unlock step of a new sequence.
- R4: Unlock followed by 90 at 5555 enters identification mode. There, reads of word 0, 1 and 2 return 001F, 0092 and the lock flag in bit 0. Every other address returns array data.
- R5: Identification mode is left either by unlock followed by F0 at 5555, or by a single F0 write to any address.
- R6: Unlock, 80 at 5555, unlock, then 10 at 5555 requests erase with `op_kind`=2 and `op_sect`=1111. When the lock is active and the override is low, this request is dropped.
- R7: Unlock, 80 at 5555, unlock, then 30 at address X requests erase of X's sector. `op_sect` bit 1 covers 02000–03FFF, bit 2 covers 04000–05FFF, and bit 3 covers all other addresses. Bit 0 (the boot range 00000–01FFF) is erased together with bit 3 unless protected.
- R8: Unlock, 80 at 5555, unlock, then 40 at 5555 sets the lock flag and issues `op_kind`=3 without going busy. The flag stays set until reset.
- R9: While the lock is set and `hv_override` is low, a program into 00000–01FFF issues no request and starts no busy period. With the override high, the program is issued.
- R10: `busy` is high for exactly PROG_CYCLES cycles after a program request and ERASE_CYCLES cycles after an erase request. Writes during that time are ignored and leave the sequence idle. After the operation, reads return array data.
- R11: A read while busy returns bit 7 equal to the inverse of bit 7 of the last programmed word (program) or 0 (erase). Bit 6 inverts on each busy read, and all other bits are 0.
- R12: `rd_valid` and `rd_data` appear exactly one cycle after `rd_en`. `arr_addr` always follows `bus_addr`.
- R13: Synchronous reset clears the requests, `busy`, `rd_valid`, the lock, identification mode and the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| bus_addr | input | AW | Word address of the access |
| bus_wdata | input | 16 | Write data |
| hv_override | input | 1 | Lifts boot-range protection while high |
| arr_addr | output | AW | Array read address |
| arr_rdata | input | 16 | Array word at `arr_addr` |
| op_valid | output | 1 | One-cycle request strobe |
| op_kind | output | 2 | 1 program, 2 erase, 3 lock |
| op_addr | output | AW | Target address of the request |
| op_data | output | 16 | Word to store for a program |
| op_sect | output | 4 | Erase mask: boot, param 1, param 2, main |
| busy | output | 1 | Program or erase in progress |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 16 | Read response word |

## Verification
The bench builds the block with PROG_CYCLES=6 and ERASE_CYCLES=15, with AW left at 18. Six cycles are enough to fit two status reads inside a program. Fifteen cycles are long enough to push a complete four-write program sequence into an erase, which shows the ignore rule works without long waits. The full 18-bit address keeps the upper-bit aliasing of the command addresses and the main sector at the top of the map in reach.

// File: rtl/flash_ci_pkg.sv
package flash_ci_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_LOCK  = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNLK1,
        SQ_UNLK2,
        SQ_PDATA,
        SQ_ERS3,
        SQ_ERS4,
        SQ_ERS5
    } seq_state_e;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] CD_KEY1  = 8'hAA;
    localparam logic [7:0] CD_KEY2  = 8'h55;
    localparam logic [7:0] CD_PROG  = 8'hA0;
    localparam logic [7:0] CD_IDENT = 8'h90;
    localparam logic [7:0] CD_LEAVE = 8'hF0;
    localparam logic [7:0] CD_ERSGP = 8'h80;
    localparam logic [7:0] CD_CHIP  = 8'h10;
    localparam logic [7:0] CD_SECT  = 8'h30;
    localparam logic [7:0] CD_LOCK  = 8'h40;

    localparam logic [WORD_W-1:0] ID_WORD0 = 16'h001F;
    localparam logic [WORD_W-1:0] ID_WORD1 = 16'h0092;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
        logic lock;
        logic id_on;
        logic id_off;
    } cmd_t;

endpackage

// File: rtl/flash_ci_seq.sv
module flash_ci_seq
    import flash_ci_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        busy,
    input  logic [14:0] cmp_addr,
    input  logic [7:0]  cmp_data,
    output cmd_t        cmd
);

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    logic       is_key1;
    logic       is_key2;
    seq_state_e fallback;

    always_comb begin
        s_d      = s_q;
        cmd      = '0;
        is_key1  = (cmp_addr == KEY_ADDR_A) && (cmp_data == CD_KEY1);
        is_key2  = (cmp_addr == KEY_ADDR_B) && (cmp_data == CD_KEY2);
        fallback = is_key1 ? SQ_UNLK1 : SQ_IDLE;

        if (wr_en && !busy) begin
            if ((s_q.st != SQ_PDATA) && (cmp_data == CD_LEAVE)) begin
                cmd.id_off = 1'b1;
                s_d.st     = SQ_IDLE;
            end else begin
                unique case (s_q.st)
                    SQ_IDLE:  s_d.st = fallback;
                    SQ_UNLK1: s_d.st = is_key2 ? SQ_UNLK2 : fallback;
                    SQ_UNLK2: begin
                        s_d.st = fallback;
                        if (cmp_addr == KEY_ADDR_A) begin
                            if (cmp_data == CD_PROG) begin
                                s_d.st = SQ_PDATA;
                            end else if (cmp_data == CD_IDENT) begin
                                cmd.id_on = 1'b1;
                                s_d.st    = SQ_IDLE;
                            end else if (cmp_data == CD_ERSGP) begin
                                s_d.st = SQ_ERS3;
                            end
                        end
                    end
                    SQ_PDATA: begin
                        cmd.prog = 1'b1;
                        s_d.st   = SQ_IDLE;
                    end
                    SQ_ERS3:  s_d.st = is_key1 ? SQ_ERS4 : SQ_IDLE;
                    SQ_ERS4:  s_d.st = is_key2 ? SQ_ERS5 : fallback;
                    SQ_ERS5: begin
                        s_d.st = fallback;
                        if (cmp_data == CD_SECT) begin
                            cmd.sect = 1'b1;
                            s_d.st   = SQ_IDLE;
                        end else if (cmp_addr == KEY_ADDR_A && cmp_data == CD_CHIP) begin
                            cmd.chip = 1'b1;
                            s_d.st   = SQ_IDLE;
                        end else if (cmp_addr == KEY_ADDR_A && cmp_data == CD_LOCK) begin
                            cmd.lock = 1'b1;
                            s_d.st   = SQ_IDLE;
                        end
                    end
                    default:  s_d.st = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(s_q.st));

    // R3
    key1_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && is_key1 && s_q.st != SQ_PDATA && s_q.st != SQ_ERS3)
        |=> (s_q.st == SQ_UNLK1));

endmodule

// File: rtl/flash_ci_sector.sv
module flash_ci_sector #(
    parameter int AW         = 18,
    parameter int SECT_SHIFT = 13
) (
    input  logic [AW-1:0] addr,
    input  logic          prot,
    output logic          in_boot,
    output logic [3:0]    ers_mask
);

    localparam int BW = AW - SECT_SHIFT;

    logic [BW-1:0] blk;

    always_comb begin
        blk     = addr[AW-1:SECT_SHIFT];
        in_boot = (blk == BW'(0));
        if (blk == BW'(1)) begin
            ers_mask = 4'b0010;
        end else if (blk == BW'(2)) begin
            ers_mask = 4'b0100;
        end else begin
            ers_mask = {1'b1, 2'b00, ~prot};
        end
    end

endmodule

// File: rtl/flash_ci_timer.sv
module flash_ci_timer #(
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_erase,
    output logic busy
);

    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PLOAD = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] ELOAD = CW'(ERASE_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = is_erase ? ELOAD : PLOAD;
        end else if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy = t_q.busy;

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R10
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (t_q.busy && t_q.cnt == '0 && !start) |=> !busy);

endmodule

// File: rtl/flash_ci_rdmux.sv
module flash_ci_rdmux
    import flash_ci_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              busy,
    input  logic              busy_erase,
    input  logic              poll_bit,
    input  logic              id_mode,
    input  logic              lock,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              tog;
    } rd_regs_t;

    rd_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = rd_en;
        if (rd_en) begin
            if (busy) begin
                r_d.data = {8'h00, (busy_erase ? 1'b0 : ~poll_bit), r_q.tog, 6'b0};
                r_d.tog  = ~r_q.tog;
            end else if (id_mode && addr == AW'(0)) begin
                r_d.data = ID_WORD0;
            end else if (id_mode && addr == AW'(1)) begin
                r_d.data = ID_WORD1;
            end else if (id_mode && addr == AW'(2)) begin
                r_d.data = {{(WORD_W-1){1'b0}}, lock};
            end else begin
                r_d.data = arr_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_valid = r_q.valid;
    assign rd_data  = r_q.data;

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R11
    status_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> (rd_data[15:8] == 8'h00 && rd_data[5:0] == 6'h00));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_ci_pkg::*;
#(
    parameter int AW           = 18,
    parameter int SECT_SHIFT   = 13,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wdata,
    input  logic          hv_override,
    output logic [AW-1:0] arr_addr,
    input  logic [15:0]   arr_rdata,
    output logic          op_valid,
    output logic [1:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [15:0]   op_data,
    output logic [3:0]    op_sect,
    output logic          busy,
    output logic          rd_valid,
    output logic [15:0]   rd_data
);

    typedef struct packed {
        logic          op_valid;
        op_kind_e      op_kind;
        logic [AW-1:0] op_addr;
        logic [15:0]   op_data;
        logic [3:0]    op_sect;
        logic          lock;
        logic          id;
        logic          poll;
        logic          ers;
    } top_regs_t;

    top_regs_t q, d;

    cmd_t       cmd;
    logic       prot;
    logic       in_boot;
    logic [3:0] ers_mask;
    logic       start;
    logic       start_erase;

    assign prot     = q.lock & ~hv_override;
    assign arr_addr = bus_addr;

    flash_ci_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .busy     (busy),
        .cmp_addr (bus_addr[14:0]),
        .cmp_data (bus_wdata[7:0]),
        .cmd      (cmd)
    );

    flash_ci_sector #(
        .AW         (AW),
        .SECT_SHIFT (SECT_SHIFT)
    ) u_sector (
        .addr     (bus_addr),
        .prot     (prot),
        .in_boot  (in_boot),
        .ers_mask (ers_mask)
    );

    always_comb begin
        d            = q;
        d.op_valid   = 1'b0;
        d.op_kind    = OP_NONE;
        start        = 1'b0;
        start_erase  = 1'b0;

        if (cmd.id_on)  d.id = 1'b1;
        if (cmd.id_off) d.id = 1'b0;

        if (cmd.prog && !(prot && in_boot)) begin
            d.op_valid = 1'b1;
            d.op_kind  = OP_PROG;
            d.op_addr  = bus_addr;
            d.op_data  = arr_rdata & bus_wdata;
            d.op_sect  = '0;
            d.poll     = bus_wdata[7];
            d.ers      = 1'b0;
            d.id       = 1'b0;
            start      = 1'b1;
        end

        if ((cmd.chip && !prot) || cmd.sect) begin
            d.op_valid  = 1'b1;
            d.op_kind   = OP_ERASE;
            d.op_addr   = cmd.chip ? '0 : bus_addr;
            d.op_sect   = cmd.chip ? 4'b1111 : ers_mask;
            d.ers       = 1'b1;
            d.id        = 1'b0;
            start       = 1'b1;
            start_erase = 1'b1;
        end

        if (cmd.lock) begin
            d.op_valid = 1'b1;
            d.op_kind  = OP_LOCK;
            d.op_addr  = bus_addr;
            d.op_sect  = '0;
            d.lock     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    flash_ci_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_erase (start_erase),
        .busy     (busy)
    );

    flash_ci_rdmux #(
        .AW (AW)
    ) u_rdmux (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .busy       (busy),
        .busy_erase (q.ers),
        .poll_bit   (q.poll),
        .id_mode    (q.id),
        .lock       (q.lock),
        .addr       (bus_addr),
        .arr_rdata  (arr_rdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign op_valid = q.op_valid;
    assign op_kind  = q.op_kind;
    assign op_addr  = q.op_addr;
    assign op_data  = q.op_data;
    assign op_sect  = q.op_sect;

    // R10
    busy_no_op_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> !op_valid);

    // R1
    prog_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_PROG) |-> ((op_data & ~$past(bus_wdata)) == 16'h0000));

    // R9
    boot_prog_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_PROG && q.lock && !$past(hv_override))
        |-> (op_addr[AW-1:SECT_SHIFT] != '0));

    // R7
    boot_erase_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_ERASE && q.lock && !$past(hv_override)) |-> !op_sect[0]);

endmodule

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 18;
    localparam int PC = 6;
    localparam int EC = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          hv_override = 1'b0;
    logic [AW-1:0] arr_addr;
    logic [15:0]   arr_rdata;
    logic          op_valid;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;
    logic [3:0]    op_sect;
    logic          busy;
    logic          rd_valid;
    logic [15:0]   rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] last_rd;

    always #2 clk = ~clk;

    function automatic logic [15:0] amodel(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[17:16], 14'h0};
    endfunction

    assign arr_rdata = amodel(arr_addr);

    flash_cmd_if #(
        .AW (AW), .SECT_SHIFT (13), .PROG_CYCLES (PC), .ERASE_CYCLES (EC)
    ) u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .hv_override (hv_override),
        .arr_addr (arr_addr), .arr_rdata (arr_rdata),
        .op_valid (op_valid), .op_kind (op_kind), .op_addr (op_addr),
        .op_data (op_data), .op_sect (op_sect), .busy (busy),
        .rd_valid (rd_valid), .rd_data (rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] dt);
        @(negedge clk);
        wr_en = 1'b1; bus_addr = a; bus_wdata = dt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        last_rd = rd_data;
        chk(rd_valid === 1'b1, "R12 rd_valid", 32'(rd_valid), 32'd1);
    endtask

    task automatic unlock(input logic [AW-1:0] hi);
        wr(hi | 18'h05555, 16'h00AA);
        wr(hi | 18'h02AAA, 16'h0055);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic ers_cmd(input logic [AW-1:0] a, input logic [7:0] code);
        unlock('0);
        wr(18'h05555, 16'h0080);
        unlock('0);
        wr(a, {8'h00, code});
    endtask

    task automatic expect_op(input string tag, input logic [1:0] k, input logic [AW-1:0] a,
                             input logic [15:0] dt, input logic [3:0] m);
        chk(op_valid === 1'b1, {tag, " valid"}, 32'(op_valid), 32'd1);
        chk(op_kind === k, {tag, " kind"}, 32'(op_kind), 32'(k));
        chk(op_addr === a, {tag, " addr"}, 32'(op_addr), 32'(a));
        if (k == 2'd1) chk(op_data === dt, {tag, " data"}, 32'(op_data), 32'(dt));
        if (k == 2'd2) chk(op_sect === m, {tag, " mask"}, 32'(op_sect), 32'(m));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic b6;
        void'($urandom(32'h1F92));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        chk(op_valid === 1'b0 && busy === 1'b0 && rd_valid === 1'b0, "R13 reset outputs",
            {29'h0, op_valid, busy, rd_valid}, 32'h0);

        // R12 plain array read and strobe width
        rd(18'h12345);
        chk(last_rd === amodel(18'h12345), "R12 array read", 32'(last_rd), 32'(amodel(18'h12345)));
        @(negedge clk);
        chk(rd_valid === 1'b0, "R12 rd_valid drops", 32'(rd_valid), 32'd0);

        // R1 program request
        unlock('0);
        wr(18'h05555, 16'h00A0);
        wr(18'h23456, 16'h0F0F);
        expect_op("R1 program", 2'd1, 18'h23456, amodel(18'h23456) & 16'h0F0F, 4'h0);
        // R11 status during program
        rd(18'h00000);
        chk(last_rd[7] === 1'b1 && last_rd[15:8] === 8'h00 && last_rd[5:0] === 6'h00,
            "R11 program status", 32'(last_rd), 32'h80);
        b6 = last_rd[6];
        rd(18'h00000);
        chk(last_rd[6] === ~b6, "R11 toggle bit", 32'(last_rd[6]), 32'(~b6));
        wait_idle();
        rd(18'h00040);
        chk(last_rd === amodel(18'h00040), "R10 read after program", 32'(last_rd), 32'(amodel(18'h00040)));

        // R10 program busy length
        unlock('0);
        wr(18'h05555, 16'h00A0);
        wr(18'h30000, 16'h00FF);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        chk(cnt == PC, "R10 program busy cycles", 32'(cnt), 32'(PC));

        // R2 aliased command addresses and junk high byte
        wr(18'h3D555, 16'hC3AA);
        wr(18'h12AAA, 16'h7E55);
        wr(18'h25555, 16'hFFA0);
        wr(18'h21111, 16'h1234);
        expect_op("R2 aliasing", 2'd1, 18'h21111, amodel(18'h21111) & 16'h1234, 4'h0);
        wait_idle();

        // R3 abort on mismatch
        wr(18'h05555, 16'h00AA);
        wr(18'h01234, 16'h0055);
        wr(18'h05555, 16'h00A0);
        wr(18'h00300, 16'h0000);
        chk(op_valid === 1'b0 && busy === 1'b0, "R3 abort", {30'h0, op_valid, busy}, 32'h0);
        // R3 restart on key write
        unlock('0);
        wr(18'h05555, 16'h00AA);
        wr(18'h02AAA, 16'h0055);
        wr(18'h05555, 16'h00A0);
        wr(18'h20002, 16'hAAAA);
        expect_op("R3 restart", 2'd1, 18'h20002, amodel(18'h20002) & 16'hAAAA, 4'h0);
        wait_idle();

        // R4 identification reads
        unlock('0);
        wr(18'h05555, 16'h0090);
        rd(18'h0); chk(last_rd === 16'h001F, "R4 id word0", 32'(last_rd), 32'h1F);
        rd(18'h1); chk(last_rd === 16'h0092, "R4 id word1", 32'(last_rd), 32'h92);
        rd(18'h2); chk(last_rd === 16'h0000, "R4 id lock", 32'(last_rd), 32'h0);
        rd(18'h7); chk(last_rd === amodel(18'h7), "R4 id other", 32'(last_rd), 32'(amodel(18'h7)));
        // R5 single-write exit
        wr(18'h01111, 16'h00F0);
        rd(18'h0); chk(last_rd === amodel(18'h0), "R5 single exit", 32'(last_rd), 32'(amodel(18'h0)));
        // R5 three-write exit
        unlock('0);
        wr(18'h05555, 16'h0090);
        unlock('0);
        wr(18'h05555, 16'h00F0);
        rd(18'h1); chk(last_rd === amodel(18'h1), "R5 sequence exit", 32'(last_rd), 32'(amodel(18'h1)));

        // R7 sector decode, unlocked
        ers_cmd(18'h03123, 8'h30);
        expect_op("R7 param1", 2'd2, 18'h03123, 16'h0, 4'b0010);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        chk(cnt == EC, "R10 erase busy cycles", 32'(cnt), 32'(EC));
        ers_cmd(18'h05000, 8'h30);
        expect_op("R7 param2", 2'd2, 18'h05000, 16'h0, 4'b0100);
        // R11 erase status, R10 writes ignored during erase
        rd(18'h0);
        chk(last_rd[7] === 1'b0, "R11 erase status", 32'(last_rd), 32'h0);
        unlock('0);
        wr(18'h05555, 16'h00A0);
        chk(op_valid === 1'b0, "R10 write in busy", 32'(op_valid), 32'd0);
        wr(18'h30001, 16'h0000);
        chk(op_valid === 1'b0, "R10 write in busy", 32'(op_valid), 32'd0);
        wait_idle();
        wr(18'h02AAA, 16'h0055);
        wr(18'h05555, 16'h00A0);
        wr(18'h30001, 16'h0000);
        chk(op_valid === 1'b0 && busy === 1'b0, "R10 sequence idle after busy",
            {30'h0, op_valid, busy}, 32'h0);
        ers_cmd(18'h3F000, 8'h30);
        expect_op("R7 main", 2'd2, 18'h3F000, 16'h0, 4'b1001);
        wait_idle();
        ers_cmd(18'h00100, 8'h30);
        expect_op("R7 boot addr", 2'd2, 18'h00100, 16'h0, 4'b1001);
        wait_idle();

        // R6 chip erase unlocked
        ers_cmd(18'h05555, 8'h10);
        expect_op("R6 chip", 2'd2, 18'h0, 16'h0, 4'b1111);
        wait_idle();

        // R8 lock
        ers_cmd(18'h05555, 8'h40);
        chk(op_valid === 1'b1 && op_kind === 2'd3, "R8 lock op", {30'h0, op_kind}, 32'd3);
        chk(busy === 1'b0, "R8 no busy", 32'(busy), 32'd0);
        unlock('0);
        wr(18'h05555, 16'h0090);
        rd(18'h2); chk(last_rd === 16'h0001, "R8 lock visible", 32'(last_rd), 32'h1);
        wr(18'h0, 16'h00F0);

        // R9 boot protection
        unlock('0);
        wr(18'h05555, 16'h00A0);
        wr(18'h01000, 16'h0000);
        chk(op_valid === 1'b0 && busy === 1'b0, "R9 boot program dropped", {30'h0, op_valid, busy}, 32'h0);
        unlock('0);
        wr(18'h05555, 16'h00A0);
        wr(18'h02000, 16'h0001);
        expect_op("R9 param program", 2'd1, 18'h02000, amodel(18'h02000) & 16'h0001, 4'h0);
        wait_idle();
        // R6 chip erase dropped, R7 main excludes boot
        ers_cmd(18'h05555, 8'h10);
        chk(op_valid === 1'b0 && busy === 1'b0, "R6 chip dropped", {30'h0, op_valid, busy}, 32'h0);
        ers_cmd(18'h3F000, 8'h30);
        expect_op("R7 main protected", 2'd2, 18'h3F000, 16'h0, 4'b1000);
        wait_idle();
        // R9 override
        hv_override = 1'b1;
        unlock('0);
        wr(18'h05555, 16'h00A0);
        wr(18'h01000, 16'h0F00);
        expect_op("R9 override program", 2'd1, 18'h01000, amodel(18'h01000) & 16'h0F00, 4'h0);
        wait_idle();
        ers_cmd(18'h3F000, 8'h30);
        expect_op("R7 override main", 2'd2, 18'h3F000, 16'h0, 4'b1001);
        wait_idle();
        ers_cmd(18'h05555, 8'h10);
        expect_op("R6 override chip", 2'd2, 18'h0, 16'h0, 4'b1111);
        wait_idle();

        // random programs and reads (R1, R9, R12)
        for (int i = 0; i < 120; i++) begin
            logic [AW-1:0] a;
            logic [15:0]   dt;
            logic          hv;
            a  = AW'($urandom);
            if ($urandom_range(0, 3) == 0) a[17:13] = 5'd0;
            dt = 16'($urandom);
            hv = 1'($urandom);
            hv_override = hv;
            unlock(AW'($urandom) & 18'h38000);
            wr(18'h05555, {8'($urandom), 8'hA0});
            wr(a, dt);
            if (a[17:13] == 5'd0 && !hv) begin
                chk(op_valid === 1'b0, "R9 random boot drop", 32'(op_valid), 32'd0);
            end else begin
                expect_op("R1 random program", 2'd1, a, amodel(a) & dt, 4'h0);
            end
            wait_idle();
            a = AW'($urandom);
            rd(a);
            chk(last_rd === amodel(a), "R12 random read", 32'(last_rd), 32'(amodel(a)));
        end

        // R13 reset clears lock
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        hv_override = 1'b0;
        unlock('0);
        wr(18'h05555, 16'h0090);
        rd(18'h2); chk(last_rd === 16'h0000, "R13 lock cleared", 32'(last_rd), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule